// File: doc/BRIEF.md
# Serial ADC Host Reader with Sleep Sequencing

This block sits on the host side of a delta-sigma converter that shares one output pin between "data ready" and "serial data". The block drives the converter's serial clock and samples that shared line. A local request port accepts one operation code at a time. The block then runs the matching clock waveform: a plain read, a read that finishes with the line forced high for polling, a self-calibration request, sleep entry, wakeup, sleep entry armed for calibration on wakeup, and a complete single conversion that wakes the converter, reads it and puts it back to sleep.

Each operation is expressed only through the number of serial-clock pulses sent once ready is seen, and through the level the clock is left at afterwards. Before each operation starts a pulse train, the block waits for the shared line to go low. A 24-bit two's-complement result is returned with a one-cycle strobe. If ready never arrives within a parameterised number of system clocks, a one-cycle error strobe ends the operation.

The clock phases are built from a divided system clock. Each bit is sampled a set number of system clocks after its rising edge, so that the converter's output delay is covered.

Top module: `adc_host_reader`

## Requirements
- R1: After reset, `sclk` is low and `busy` is high until `sdo` is first observed low. After that, `busy` falls within three clock cycles.
- R2: Operation codes on `cmd_op`: 0 read, 1 read-and-release, 2 calibrate, 3 sleep, 4 sleep-with-calibration, 5 wake, 6 single conversion. Code 7 is ignored. Every code except 3 first drives `sclk` low. It then waits until `sdo` is low and `sclk` has been low for at least HALF cycles before the first rising edge.
- R3: Every high phase and every low phase of `sclk` lasts at least HALF system-clock cycles.
- R4: Read (0) sends exactly 24 rising edges. Bits are taken SAMPLE_AT cycles after each rising edge, first bit into result bit 23. The 24-bit word appears on `result` with `result_valid` high for one cycle. `sclk` is left low.
- R5: Read-and-release (1) sends exactly 25 rising edges, returns the word as in R4, and leaves `sclk` low.
- R6: Calibrate (2) sends exactly 26 rising edges and leaves `sclk` low. It stays busy until `sdo` falls again, and gives no `result_valid`.
- R7: Sleep (3) raises `sclk` and leaves it high. `busy` lasts HALF cycles. No pulses follow.
- R8: Sleep-with-calibration (4) sends 25 rising edges, then raises `sclk` and leaves it high, with no `result_valid`.
- R9: Wake (5) drives `sclk` low and stays busy until `sdo` is low. It sends no rising edge.
- R10: Single conversion (6) drives `sclk` low, waits for ready and reads 24 bits. It returns the word, then raises `sclk` and leaves it high.
- R11: If a wait for `sdo` low exceeds TIMEOUT_CYC cycles, `timeout_err` pulses for one cycle, `busy` falls and no `result_valid` is given.
- R12: `busy` is high from acceptance of a request until its sequence ends. Requests presented while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Request strobe, taken only when idle |
| cmd_op | input | 3 | Operation code |
| sdo | input | 1 | Converter ready/data line |
| sclk | output | 1 | Serial clock to the converter |
| result | output | 24 | Last word read, two's complement |
| result_valid | output | 1 | One-cycle strobe with a new word |
| timeout_err | output | 1 | One-cycle strobe when ready never came |
| busy | output | 1 | Sequence in progress |

## Verification
Some properties hold on every cycle, and the assertions check them there. Both `sclk` phases keep their minimum width. A rising edge that leaves the wait for ready only happens after `sdo` was seen low. The result and timeout strobes never coincide. The operation cannot change while busy. The pulse count stays within 26. When busy ends, the clock rests at the level the operation calls for.

Other behaviour can only be shown by the bench's scenarios. These are the exact pulse count of each operation and the bit order of the returned word over boundary codes. They also cover the calibration wait on the line, the timeout path with its missing result, and the sleep, wake and single-conversion sequence run against a converter model.

// File: rtl/adc_host_reader.sv
`timescale 1ns/1ps
module adc_host_reader #(
  parameter int HALF        = 20,
  parameter int SAMPLE_AT   = 12,
  parameter int TIMEOUT_CYC = 2000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_op,
  input  logic        sdo,
  output logic        sclk,
  output logic [23:0] result,
  output logic        result_valid,
  output logic        timeout_err,
  output logic        busy
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam int RW = $clog2(HALF + 1);
  localparam logic [2:0] OP_READ = 3'd0, OP_REL = 3'd1, OP_CAL = 3'd2, OP_SLEEP = 3'd3,
                         OP_SLCAL = 3'd4, OP_WAKE = 3'd5, OP_SINGLE = 3'd6;

  typedef enum logic [2:0] {S_BOOT, S_IDLE, S_WAIT, S_HI, S_LO, S_CALW, S_HOLD} st_t;
  st_t         state;
  logic [CW-1:0] cnt;
  logic [4:0]  npulse, target;
  logic [23:0] shreg;
  logic [2:0]  op;
  logic        sclk_r;

  assign sclk = sclk_r;
  assign busy = (state != S_IDLE);

  always_comb begin
    case (op)
      OP_REL, OP_SLCAL: target = 5'd25;
      OP_CAL:           target = 5'd26;
      default:          target = 5'd24;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_BOOT; cnt <= '0; npulse <= '0; shreg <= '0; op <= OP_READ;
      sclk_r <= 1'b0; result <= '0; result_valid <= 1'b0; timeout_err <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      timeout_err  <= 1'b0;
      case (state)
        S_BOOT, S_CALW: begin
          if (!sdo) begin
            state <= S_IDLE;
          end else if (cnt == CW'(TIMEOUT_CYC - 1)) begin
            timeout_err <= 1'b1; state <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        S_IDLE: begin
          if (cmd_valid && cmd_op != 3'd7) begin
            op <= cmd_op; cnt <= '0; npulse <= '0;
            if (cmd_op == OP_SLEEP) begin
              sclk_r <= 1'b1; state <= S_HOLD;
            end else begin
              sclk_r <= 1'b0; state <= S_WAIT;
            end
          end
        end
        S_WAIT: begin
          if (!sdo && cnt >= CW'(HALF - 1)) begin
            cnt <= '0;
            if (op == OP_WAKE) state <= S_IDLE;
            else begin
              sclk_r <= 1'b1; npulse <= 5'd1; state <= S_HI;
            end
          end else if (cnt == CW'(TIMEOUT_CYC - 1)) begin
            timeout_err <= 1'b1; state <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        S_HI: begin
          if (cnt == CW'(SAMPLE_AT - 1) && npulse <= 5'd24) shreg <= {shreg[22:0], sdo};
          if (cnt == CW'(HALF - 1)) begin
            cnt <= '0; sclk_r <= 1'b0; state <= S_LO;
          end else cnt <= cnt + 1'b1;
        end
        S_LO: begin
          if (cnt == CW'(HALF - 1)) begin
            cnt <= '0;
            if (npulse != target) begin
              npulse <= npulse + 1'b1; sclk_r <= 1'b1; state <= S_HI;
            end else begin
              case (op)
                OP_CAL:    state <= S_CALW;
                OP_SLCAL:  begin sclk_r <= 1'b1; state <= S_HOLD; end
                OP_SINGLE: begin
                  result <= shreg; result_valid <= 1'b1; sclk_r <= 1'b1; state <= S_HOLD;
                end
                default:   begin result <= shreg; result_valid <= 1'b1; state <= S_IDLE; end
              endcase
            end
          end else cnt <= cnt + 1'b1;
        end
        S_HOLD: begin
          if (cnt == CW'(HALF - 1)) state <= S_IDLE;
          else cnt <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // Phase-width monitor: run counts cycles since the last sclk change.
  logic          sclk_q;
  logic [RW-1:0] run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0; run <= RW'(HALF);
    end else begin
      sclk_q <= sclk_r;
      if (sclk_r != sclk_q) run <= RW'(1);
      else if (run < RW'(HALF)) run <= run + 1'b1;
    end
  end

  assert_phase_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_r != sclk_q) |-> (run >= RW'(HALF - 1)));

  assert_edge_after_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sclk_r) && ($past(state) == S_WAIT)) |-> !$past(sdo));

  assert_strobes_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(result_valid && timeout_err));

  assert_op_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(op));

  assert_pulse_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    npulse <= 5'd26);

  assert_rest_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !timeout_err) |->
      (sclk_r == (op == OP_SLEEP || op == OP_SLCAL || op == OP_SINGLE)));
endmodule

// File: tb/adc_host_reader_tb_top.sv
`timescale 1ns/1ps
module adc_host_reader_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0, sdo = 1'b1;
  logic [2:0] cmd_op = 3'd0;
  logic sclk, result_valid, timeout_err, busy;
  logic [23:0] result;

  adc_host_reader dut_i (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .sdo(sdo), .sclk(sclk), .result(result), .result_valid(result_valid),
    .timeout_err(timeout_err), .busy(busy));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, edges = 0, pcnt = 0;
  logic [23:0] word = '0;
  logic got_valid, got_to;
  logic [23:0] got_res;

  // Converter model: data after 40 ns, 25th edge forces high, 26th fall starts calibration.
  always @(posedge sclk) begin
    edges = edges + 1;
    pcnt = pcnt + 1;
    if (pcnt <= 24) sdo <= #40 word[24 - pcnt];
    else if (pcnt == 25) sdo <= #40 1'b1;
  end
  always @(negedge sclk) if (pcnt == 26) sdo <= #3000 1'b0;

  localparam int NV = 6;
  localparam logic [23:0] VEC [NV] = '{24'h7FFFFF, 24'h800000, 24'h000001,
                                       24'hFFFFFF, 24'h000000, 24'hA5C3E1};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic present(input logic [23:0] w);
    sdo = 1'b1; #20; word = w; pcnt = 0; sdo = 1'b0;
  endtask

  task automatic issue(input logic [2:0] op);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic run_cmd(input logic [2:0] op);
    edges = 0; got_valid = 0; got_to = 0; got_res = '0;
    issue(op);
    for (int i = 0; i < 30000; i++) begin
      @(negedge clk);
      if (result_valid) begin got_valid = 1; got_res = result; end
      if (timeout_err) got_to = 1;
      if (!busy) break;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 power-up
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R1 sclk low at boot", sclk, 0);
    chk("R1 busy during boot", busy, 1);
    sdo = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 busy cleared by ready", busy, 0);

    // R4 table of read vectors
    for (int v = 0; v < NV; v++) begin
      present(VEC[v]);
      run_cmd(3'd0);
      chk("R4 read word", got_res, VEC[v]);
      chk("R4 read valid", got_valid, 1);
      chk("R4 read edges", edges, 24);
      chk("R4 sclk low after read", sclk, 0);
    end

    // R5 read and release
    present(24'h3C5A96);
    run_cmd(3'd1);
    chk("R5 word", got_res, 24'h3C5A96);
    chk("R5 edges", edges, 25);
    repeat (20) @(negedge clk);
    chk("R5 line released high", sdo, 1);

    // R6 calibrate, R12 request ignored while busy
    present(24'h123456);
    fork
      run_cmd(3'd2);
      begin repeat (400) @(negedge clk); cmd_valid = 1'b1; cmd_op = 3'd0;
            @(negedge clk); cmd_valid = 1'b0; end
    join
    chk("R6 cal edges", edges, 26);
    chk("R6 no result", got_valid, 0);
    chk("R6 ended on ready low", sdo, 0);
    chk("R6 sclk low", sclk, 0);
    repeat (200) @(negedge clk);
    chk("R12 busy request ignored", busy, 0);
    chk("R12 no extra edges", edges, 26);

    // R2 code 7 ignored
    edges = 0; issue(3'd7);
    repeat (50) @(negedge clk);
    chk("R2 code 7 busy", busy, 0);
    chk("R2 code 7 edges", edges, 0);

    // R7 sleep
    run_cmd(3'd3);
    repeat (100) @(negedge clk);
    chk("R7 sclk held high", sclk, 1);
    chk("R7 single raise only", edges, 1);

    // R9 wake
    sdo = 1'b1;
    fork
      run_cmd(3'd5);
      begin repeat (60) @(negedge clk);
            chk("R9 sclk low while waiting", sclk, 0);
            chk("R12 busy while waiting", busy, 1);
            present(24'h0); end
    join
    chk("R9 wake edges", edges, 0);
    chk("R9 wake no result", got_valid, 0);

    // R8 sleep with calibration
    present(24'hFEDCBA);
    run_cmd(3'd4);
    chk("R8 edges", edges, 26);  // 25 pulses plus the final raise
    chk("R8 sclk high", sclk, 1);
    chk("R8 no result", got_valid, 0);

    // R10 single conversion
    fork
      run_cmd(3'd6);
      begin wait (sclk == 1'b0); repeat (30) @(negedge clk); present(24'h5AA5C3); end
    join
    chk("R10 word", got_res, 24'h5AA5C3);
    chk("R10 edges", edges, 25);  // 24 data pulses plus the sleep raise
    chk("R10 sclk back high", sclk, 1);

    // R11 timeout
    sdo = 1'b1;
    run_cmd(3'd0);
    chk("R11 timeout strobe", got_to, 1);
    chk("R11 no result", got_valid, 0);
    chk("R11 no edges", edges, 0);
    chk("R11 busy dropped", busy, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule